// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit control words inside a system control unit. Software reaches it through a simple word-addressed port with separate read and write strobes. A protection key guards every other word. Writing a fixed magic value to word 0 unlocks the bank. Any other value locks it again. Word 0 keeps only that one-bit verdict.

Reset control and clock-stop control are built as set/clear pairs. Writing to a set word ORs the data in. Writing to the word just above it clears the bits that are 1 in the data. Two strap words follow the same scheme. Each strap word also has a protect word two places above it, and that protect word can freeze the strap's set path.

The bank also holds:
- revision and identity words that software cannot write;
- three PLL extension words that always read back as locked;
- a random-data word that returns an external random input on every read.

At reset, every word takes a parameter default. The strap words, the key and the second revision word are then loaded from input ports.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset:
  - lock_err is 0;
  - word 0 reads {31'b0, key_in};
  - words 12 and 16 hold strap_a_in and strap_b_in;
  - word 2 holds rev_in;
  - word 1 holds REV_ID, words 25 and 26 hold ID0_INIT and ID1_INIT;
  - words 4, 6, 8 and 10 hold RSTA_INIT, RSTB_INIT, CSTA_INIT and CSTB_INIT;
  - words 20 to 22 hold PLL_INIT;
  - every other word holds 0.
- R2: A write to word 0 stores 1 if wdata equals UNLOCK_MAGIC and 0 otherwise. Word 0 reads back as {31'b0, key}.
- R3: While the key is 0, a write to any in-range word other than word 0 is dropped and sets lock_err. lock_err stays 1 until reset. Writes to word 0 are always accepted.
- R4: With ENFORCE_LOCK=0, a write made while the key is 0 is still performed, and lock_err is still set.
- R5: Set words 4, 6, 8 and 10: a write ORs wdata into the stored value.
- R6: Clear words 5, 7, 9 and 11 (set word + 1): a write ANDs ~wdata into the word below. Clear words always read 0.
- R7: Strap words 12 and 16 are set by OR. A set write is ignored while the protect word (strap + 2, that is word 14 or 18) is nonzero. The strap clear words 13 and 17 clear bits regardless of the protect word.
- R8: Writes to words 1, 2, 24, 25 and 26 are ignored.
- R9: Reads of words 20, 21 and 22 return the stored value with bit 31 forced to 1.
- R10: A read of word 24 returns rnd_word as sampled at the read edge, and stores that value in word 24.
- R11: Addresses at or above NREGS read 0. Writes to them change no word.
- R12: rdata is registered:
  - it shows the read result one clock after rd_en;
  - it holds its value while rd_en is low;
  - a read and a write to the same word in the same cycle return the old value.
- R13: All other in-range words (3, 14, 15, 18, 19, 23, 27 and up) store wdata as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rnd_word | input | 32 | External random word |
| strap_a_in | input | 32 | Reset value of strap word A |
| strap_b_in | input | 32 | Reset value of strap word B |
| key_in | input | 1 | Reset value of the unlock bit |
| rev_in | input | 32 | Reset value of the second revision word |
| lock_err | output | 1 | Sticky lock-violation flag |

## Verification
The properties assume the following about the inputs:
- rd_en, wr_en and addr are known, and held for a whole clock, in every cycle after reset;
- rnd_word is stable at the read edge, so the random-read property can compare rdata with the sampled value.

The stimulus meets these assumptions by changing every input only on the falling edge, and by never changing rnd_word in the cycle that a read to word 24 is captured. A second instance with enforcement switched off shares the same inputs. Its properties are the same, because none of them relies on writes being dropped.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int          AW           = 6,
  parameter int          NREGS        = 32,
  parameter logic [31:0] UNLOCK_MAGIC = 32'hC0DE_7A11,
  parameter bit          ENFORCE_LOCK = 1'b1,
  parameter logic [31:0] REV_ID       = 32'h0A11_0003,
  parameter logic [31:0] RSTA_INIT    = 32'hF0C3_FE00,
  parameter logic [31:0] RSTB_INIT    = 32'h0FFF_FFF0,
  parameter logic [31:0] CSTA_INIT    = 32'hFFFF_0F0A,
  parameter logic [31:0] CSTB_INIT    = 32'hFF00_FF00,
  parameter logic [31:0] PLL_INIT     = 32'h0000_0031,
  parameter logic [31:0] ID0_INIT     = 32'h600D_F00D,
  parameter logic [31:0] ID1_INIT     = 32'h0C0F_FEE5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [31:0]   rnd_word,
  input  logic [31:0]   strap_a_in,
  input  logic [31:0]   strap_b_in,
  input  logic          key_in,
  input  logic [31:0]   rev_in,
  output logic          lock_err
);
  localparam int IW = $clog2(NREGS);
  localparam int W_KEY = 0, W_REV = 1, W_REV2 = 2;
  localparam int W_RSTA = 4, W_RSTB = 6, W_CSTA = 8, W_CSTB = 10;
  localparam int W_STRA = 12, W_STRB = 16;
  localparam int W_PLL0 = 20, W_PLL1 = 21, W_PLL2 = 22;
  localparam int W_RND = 24, W_ID0 = 25, W_ID1 = 26;

  function automatic logic [31:0] dflt(input int i);
    case (i)
      W_REV:                  return REV_ID;
      W_RSTA:                 return RSTA_INIT;
      W_RSTB:                 return RSTB_INIT;
      W_CSTA:                 return CSTA_INIT;
      W_CSTB:                 return CSTB_INIT;
      W_PLL0, W_PLL1, W_PLL2: return PLL_INIT;
      W_ID0:                  return ID0_INIT;
      W_ID1:                  return ID1_INIT;
      default:                return 32'h0;
    endcase
  endfunction

  function automatic logic is_strap(input int i);
    return i == W_STRA || i == W_STRB;
  endfunction

  function automatic logic is_set(input int i);
    return i == W_RSTA || i == W_RSTB || i == W_CSTA || i == W_CSTB || is_strap(i);
  endfunction

  function automatic logic is_clr(input int i);
    return i > 0 && is_set(i - 1);
  endfunction

  function automatic logic is_ro(input int i);
    return i == W_REV || i == W_REV2 || i == W_RND || i == W_ID0 || i == W_ID1;
  endfunction

  function automatic logic is_pll(input int i);
    return i == W_PLL0 || i == W_PLL1 || i == W_PLL2;
  endfunction

  logic [31:0]   regs [NREGS];
  logic [IW-1:0] idx, idx_dn, idx_pr;
  logic          in_rng, unlocked, wr_ok;

  assign idx      = addr[IW-1:0];
  assign idx_dn   = idx - IW'(1);
  assign idx_pr   = idx + IW'(2);
  assign in_rng   = 32'(addr) < NREGS;
  assign unlocked = regs[W_KEY][0];
  assign wr_ok    = wr_en && in_rng && (unlocked || addr == '0 || !ENFORCE_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= dflt(i);
      regs[W_KEY]  <= {31'b0, key_in};
      regs[W_REV2] <= rev_in;
      regs[W_STRA] <= strap_a_in;
      regs[W_STRB] <= strap_b_in;
      rdata        <= '0;
      lock_err     <= 1'b0;
    end else begin
      if (rd_en)
        rdata <= !in_rng              ? 32'h0 :
                 int'(idx) == W_RND   ? rnd_word :
                 is_pll(int'(idx))    ? (regs[idx] | 32'h8000_0000) : regs[idx];
      if (rd_en && in_rng && int'(idx) == W_RND) regs[W_RND] <= rnd_word;
      if (wr_en && in_rng && addr != '0 && !unlocked) lock_err <= 1'b1;
      if (wr_ok) begin
        if (int'(idx) == W_KEY)
          regs[W_KEY] <= {31'b0, wdata == UNLOCK_MAGIC};
        else if (is_clr(int'(idx)))
          regs[idx_dn] <= regs[idx_dn] & ~wdata;
        else if (is_set(int'(idx))) begin
          if (!is_strap(int'(idx)) || regs[idx_pr] == 32'h0)
            regs[idx] <= regs[idx] | wdata;
        end else if (!is_ro(int'(idx)))
          regs[idx] <= wdata;
      end
    end
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int          AW           = 6,
  parameter int          NREGS        = 32,
  parameter logic [31:0] UNLOCK_MAGIC = 32'hC0DE_7A11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rnd_word,
  input logic [31:0]   rdata,
  input logic          lock_err,
  input logic          unlocked
);
  // R2
  key_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == '0 |=> unlocked == ($past(wdata) == UNLOCK_MAGIC));
  // R3
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && !(wr_en && addr == '0) |=> !unlocked);
  // R3
  lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !unlocked && addr != '0 && 32'(addr) < NREGS |=> lock_err);
  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> lock_err);
  // R9
  pll_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == AW'(20) || addr == AW'(21) || addr == AW'(22)) |=> rdata[31]);
  // R10
  rnd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'(24) |=> rdata == $past(rnd_word));
  // R11
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && 32'(addr) >= NREGS |=> rdata == 32'h0);
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.AW(AW), .NREGS(NREGS), .UNLOCK_MAGIC(UNLOCK_MAGIC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rnd_word(rnd_word), .rdata(rdata), .lock_err(lock_err), .unlocked(unlocked));

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;
  localparam logic [31:0] MAGIC = 32'hC0DE_7A11;
  localparam logic [31:0] REV = 32'h0A11_0003, RSTA = 32'hF0C3_FE00, RSTB = 32'h0FFF_FFF0;
  localparam logic [31:0] CSTA = 32'hFFFF_0F0A, CSTB = 32'hFF00_FF00, PLL = 32'h0000_0031;
  localparam logic [31:0] ID0 = 32'h600D_F00D, ID1 = 32'h0C0F_FEE5;
  localparam logic [31:0] STRA_IN = 32'h0000_F0A5, STRB_IN = 32'h1234_0000, REV_IN = 32'h0503_0303;

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, key_in = 0;
  logic [5:0]  addr = 0;
  logic [31:0] wdata = 0, rnd_word = 32'h1111_2222;
  logic [31:0] rdata, rdata_f;
  logic        lock_err, lock_err_f;
  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] m [64];
  logic        m_lock;

  always #4 clk = ~clk;

  sysctl_regbank #(.UNLOCK_MAGIC(MAGIC), .ENFORCE_LOCK(1'b1), .REV_ID(REV), .RSTA_INIT(RSTA),
    .RSTB_INIT(RSTB), .CSTA_INIT(CSTA), .CSTB_INIT(CSTB), .PLL_INIT(PLL), .ID0_INIT(ID0),
    .ID1_INIT(ID1)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rnd_word(rnd_word), .strap_a_in(STRA_IN), .strap_b_in(STRB_IN),
    .key_in(key_in), .rev_in(REV_IN), .lock_err(lock_err));

  sysctl_regbank #(.UNLOCK_MAGIC(MAGIC), .ENFORCE_LOCK(1'b0)) u_free (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_f), .rnd_word(rnd_word), .strap_a_in(STRA_IN), .strap_b_in(STRB_IN),
    .key_in(key_in), .rev_in(REV_IN), .lock_err(lock_err_f));

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      finish_up();
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input int a);
    if (a >= 32) return "R11";
    if (a == 0) return "R2";
    if (a == 1 || a == 2 || a == 25 || a == 26) return "R8";
    if (a == 24) return "R10";
    if (a >= 20 && a <= 22) return "R9";
    if (a == 12 || a == 16 || a == 13 || a == 17) return "R7";
    if (a == 4 || a == 6 || a == 8 || a == 10) return "R5";
    if (a == 5 || a == 7 || a == 9 || a == 11) return "R6";
    return "R13";
  endfunction

  task automatic mdl_reset();
    for (int a = 0; a < 64; a++) m[a] = 0;
    m[0] = {31'b0, key_in}; m[1] = REV; m[2] = REV_IN;
    m[4] = RSTA; m[6] = RSTB; m[8] = CSTA; m[10] = CSTB;
    m[12] = STRA_IN; m[16] = STRB_IN;
    m[20] = PLL; m[21] = PLL; m[22] = PLL; m[25] = ID0; m[26] = ID1;
    m_lock = 0;
  endtask

  task automatic mdl_write(input int a, input logic [31:0] d);
    if (a >= 32) return;
    if (a != 0 && !m[0][0]) begin m_lock = 1; return; end
    if (a == 0) m[0] = {31'b0, d == MAGIC};
    else if (a == 5 || a == 7 || a == 9 || a == 11 || a == 13 || a == 17) m[a-1] = m[a-1] & ~d;
    else if (a == 4 || a == 6 || a == 8 || a == 10) m[a] = m[a] | d;
    else if (a == 12 || a == 16) begin if (m[a+2] == 0) m[a] = m[a] | d; end
    else if (!(a == 1 || a == 2 || a == 24 || a == 25 || a == 26)) m[a] = d;
  endtask

  function automatic logic [31:0] mdl_read(input int a);
    if (a >= 32) return 0;
    if (a == 24) return rnd_word;
    if (a >= 20 && a <= 22) return m[a] | 32'h8000_0000;
    return m[a];
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 6'(a); wdata = d;
    @(negedge clk); wr_en = 0;
    mdl_write(a, d);
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = 6'(a);
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic rd_chk(input int a, input string tag);
    logic [31:0] v, e;
    rnd_word = rnd_word * 32'd1103515245 + 32'd12345;
    e = mdl_read(a);
    rd(a, v);
    chk(v, e, tag);
  endtask

  initial begin
    logic [31:0] v;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({31'b0, lock_err}, 0, "R1 lock_err after reset");
    for (int a = 0; a < 64; a++) rd_chk(a, a < 32 ? "R1" : "R11");

    // locked writes: enforcing instance drops, free instance stores
    wr(30, 32'h0000_DEAD);
    chk({31'b0, lock_err}, 1, "R3 flag on locked write");
    rd(30, v);
    chk(v, 0, "R3 locked write dropped");
    chk(rdata_f, 32'h0000_DEAD, "R4 write proceeds without enforcement");
    chk({31'b0, lock_err_f}, 1, "R4 flag still set");

    wr(0, MAGIC ^ 32'h1);
    rd_chk(0, "R2 wrong key");
    wr(0, MAGIC);
    rd_chk(0, "R2 magic key");
    chk({31'b0, lock_err}, 1, "R3 flag sticky");

    for (int p = 0; p < 2; p++) begin
      for (int a = 1; a < 64; a++) begin
        logic [7:0] b;
        logic [31:0] d;
        b = 8'(a);
        d = 32'h1357_9BDF ^ {b, b, b, b};
        if (p == 1) d = ~d;
        wr(a, d);
        rd_chk(a, tag_of(a));
      end
      for (int a = 0; a < 64; a++) rd_chk(a, tag_of(a));
    end

    // explicit clear and gated strap
    wr(14, 32'h0); wr(12, 32'h0000_0F00); rd_chk(12, "R7 set open");
    wr(14, 32'h1); wr(12, 32'h00F0_0000); rd_chk(12, "R7 set blocked");
    wr(13, 32'hFFFF_FFFF); rd_chk(12, "R7 clear ungated");
    wr(4, 32'h0000_00FF); wr(5, 32'h0000_000F); rd_chk(4, "R5 R6 set then clear");
    rd_chk(5, "R6 clear word reads zero");

    // same-cycle read and write to one word
    wr(28, 32'hAAAA_0001);
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 6'd28; wdata = 32'h5555_0002;
    @(negedge clk); rd_en = 0; wr_en = 0;
    chk(rdata, 32'hAAAA_0001, "R12 old value on collision");
    mdl_write(28, 32'h5555_0002);
    addr = 6'd3; repeat (3) @(negedge clk);
    chk(rdata, 32'hAAAA_0001, "R12 rdata holds without read");
    rd_chk(28, "R12 new value after collision");

    rnd_word = 32'hFEED_0001; rd(24, v); chk(v, 32'hFEED_0001, "R10 random read");
    rnd_word = 32'hFEED_0002; rd(24, v); chk(v, 32'hFEED_0002, "R10 fresh random read");

    wr(0, 32'h0);
    rd_chk(0, "R2 relock");
    wr(4, 32'hFFFF_FFFF);
    rd_chk(4, "R3 write dropped after relock");
    finish_up();
  end
endmodule